// File: doc/BRIEF.md
# Receiver Power State Controller

This block sets the power state of an eight-channel receive path. Two complete power profiles are held on its inputs. Each profile has a per-channel enable mask, a nap-or-sleep choice for the converter section and a nap-or-sleep choice for the analog front end. An asynchronous profile-select pin picks which profile is in force. An asynchronous continuous-wave request pin moves the converter section into its low-power state while the front end keeps running.

The outputs are registered. They are the per-channel enables, a three-valued mode for the converter section and another for the front end, a wake-busy flag, and run flags for the circuit domains that stay up in each state. When a section returns to active, the wake-busy flag stays high for a programmed number of clock cycles. One count applies when the section wakes from nap and another when it wakes from sleep. If a new low-power request arrives while a wake count is still running, the wake is dropped and the new state takes effect at once.

Top module: `pwr_state_ctrl`

## Requirements
- R1: When the converter is active, `ch_en` equals the channel mask of the selected profile: `prof0_ch_mask` while the synchronized `prof_sel_async` is 0, and `prof1_ch_mask` while it is 1. Bit n of `ch_en` is channel n.
- R2: The converter leaves active when the selected mask is all zero, or when the synchronized `cw_req_async` is 1. It then goes to nap if the selected profile's converter nap bit is 1, and to sleep if that bit is 0. The mode encoding is active = 0, nap = 1, sleep = 2.
- R3: The front end leaves active only when the selected mask is all zero. It then goes to nap if the selected profile's front-end nap bit is 1, and to sleep if that bit is 0. `cw_req_async` has no effect on the front end.
- R4: No bit of `ch_en` is set while the converter mode is nap or sleep.
- R5: A change on `prof_sel_async` or `cw_req_async` passes through a two-flop synchronizer and reaches the outputs at the third rising edge. A change on a profile input reaches the outputs at the first rising edge.
- R6: When a section goes from nap to active, `wake_busy` is high for exactly `nap_wake_cyc` cycles. When it goes from sleep to active, `wake_busy` is high for exactly `sleep_wake_cyc` cycles. A count of zero gives no busy cycle.
- R7: If the request goes back to a low-power state while a wake count runs, `wake_busy` falls and the new mode appears at the next rising edge.
- R8: `ref_run`, `dce_run` and `pll_run` are 1 unless the converter mode is sleep. `bg_run` is always 1.
- R9: While `rst` is high, at each rising edge `ch_en` is cleared, both modes become sleep and `wake_busy` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prof_sel_async | input | 1 | Asynchronous profile select (0 = profile 0, 1 = profile 1) |
| cw_req_async | input | 1 | Asynchronous continuous-wave request |
| prof0_ch_mask | input | NCH | Channel mask, profile 0 |
| prof1_ch_mask | input | NCH | Channel mask, profile 1 |
| prof0_cnv_nap | input | 1 | Profile 0 converter low-power choice (1 = nap, 0 = sleep) |
| prof1_cnv_nap | input | 1 | Profile 1 converter low-power choice |
| prof0_fe_nap | input | 1 | Profile 0 front-end low-power choice |
| prof1_fe_nap | input | 1 | Profile 1 front-end low-power choice |
| nap_wake_cyc | input | CW | Wake-busy length after nap, in cycles |
| sleep_wake_cyc | input | CW | Wake-busy length after sleep, in cycles |
| ch_en | output | NCH | Per-channel enables |
| cnv_mode | output | 2 | Converter mode (0 active, 1 nap, 2 sleep) |
| fe_mode | output | 2 | Front-end mode (0 active, 1 nap, 2 sleep) |
| wake_busy | output | 1 | Wake-up in progress |
| ref_run | output | 1 | Reference domain running |
| dce_run | output | 1 | Clock duty-cycle equalizer domain running |
| pll_run | output | 1 | Clock multiplier PLL domain running |
| bg_run | output | 1 | Bandgap domain running |

## Verification
The hardest situation to reach is an aborted wake: a wake count must be running when a fresh low-power request arrives. The stimulus first parks the block in sleep with a long sleep count. It then enables a channel so that the count starts. Two cycles later it clears the mask again, and it checks that the busy flag and the mode both change at the very next edge. The exact busy length is measured by counting busy cycles over a fixed window after each wake. This is done for nap, for sleep and for a zero count.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE = 2'd0,
        PM_NAP    = 2'd1,
        PM_SLEEP  = 2'd2
    } pmode_t;

    typedef struct packed {
        pmode_t cnv;
        pmode_t fe;
    } mode_pair_t;

    localparam int SECTIONS = 2;

    function automatic pmode_t lp_pick(input logic nap_sel);
        return nap_sel ? PM_NAP : PM_SLEEP;
    endfunction

endpackage

// File: rtl/pwr_sync2.sv
module pwr_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d_async[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
    import pwr_state_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           sel,
    input  logic           cw,
    input  logic [NCH-1:0] mask0,
    input  logic [NCH-1:0] mask1,
    input  logic           cnap0,
    input  logic           cnap1,
    input  logic           fnap0,
    input  logic           fnap1,
    output logic [NCH-1:0] en,
    output mode_pair_t     modes
);
    logic [NCH-1:0] mask;
    logic           cnap, fnap, none_on;

    always_comb begin
        mask    = sel ? mask1 : mask0;
        cnap    = sel ? cnap1 : cnap0;
        fnap    = sel ? fnap1 : fnap0;
        none_on = ~|mask;
        modes.cnv = (none_on || cw) ? lp_pick(cnap) : PM_ACTIVE;
        modes.fe  = none_on ? lp_pick(fnap) : PM_ACTIVE;
        en = (modes.cnv == PM_ACTIVE) ? mask : '0;
    end
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer
    import pwr_state_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  pmode_t        cur_mode,
    input  pmode_t        nxt_mode,
    input  logic [CW-1:0] nap_n,
    input  logic [CW-1:0] sleep_n,
    output logic          busy
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (nxt_mode != PM_ACTIVE) begin
            cnt <= '0;
        end else if (cur_mode != PM_ACTIVE) begin
            cnt <= (cur_mode == PM_SLEEP) ? sleep_n : nap_n;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_state_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 24
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           prof_sel_async,
    input  logic           cw_req_async,
    input  logic [NCH-1:0] prof0_ch_mask,
    input  logic [NCH-1:0] prof1_ch_mask,
    input  logic           prof0_cnv_nap,
    input  logic           prof1_cnv_nap,
    input  logic           prof0_fe_nap,
    input  logic           prof1_fe_nap,
    input  logic [CW-1:0]  nap_wake_cyc,
    input  logic [CW-1:0]  sleep_wake_cyc,
    output logic [NCH-1:0] ch_en,
    output logic [1:0]     cnv_mode,
    output logic [1:0]     fe_mode,
    output logic           wake_busy,
    output logic           ref_run,
    output logic           dce_run,
    output logic           pll_run,
    output logic           bg_run
);
    localparam int NSYNC = 2;

    logic [NSYNC-1:0] pins_s;
    logic [NCH-1:0]   en_nxt, en_q;
    mode_pair_t       m_nxt, m_q;
    pmode_t           cur_m [SECTIONS];
    pmode_t           nxt_m [SECTIONS];
    logic [SECTIONS-1:0] sect_busy;
    logic             dom_q;

    pwr_sync2 #(.W(NSYNC)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({cw_req_async, prof_sel_async}),
        .q       (pins_s)
    );

    pwr_mode_decode #(.NCH(NCH)) u_dec (
        .sel   (pins_s[0]),
        .cw    (pins_s[1]),
        .mask0 (prof0_ch_mask),
        .mask1 (prof1_ch_mask),
        .cnap0 (prof0_cnv_nap),
        .cnap1 (prof1_cnv_nap),
        .fnap0 (prof0_fe_nap),
        .fnap1 (prof1_fe_nap),
        .en    (en_nxt),
        .modes (m_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            m_q   <= '{cnv: PM_SLEEP, fe: PM_SLEEP};
            dom_q <= 1'b0;
        end else begin
            en_q  <= en_nxt;
            m_q   <= m_nxt;
            dom_q <= (m_nxt.cnv != PM_SLEEP);
        end
    end

    assign cur_m[0] = m_q.cnv;
    assign nxt_m[0] = m_nxt.cnv;
    assign cur_m[1] = m_q.fe;
    assign nxt_m[1] = m_nxt.fe;

    for (genvar s = 0; s < SECTIONS; s++) begin : g_sect
        pwr_wake_timer #(.CW(CW)) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .cur_mode (cur_m[s]),
            .nxt_mode (nxt_m[s]),
            .nap_n    (nap_wake_cyc),
            .sleep_n  (sleep_wake_cyc),
            .busy     (sect_busy[s])
        );
    end

    assign ch_en     = en_q;
    assign cnv_mode  = m_q.cnv;
    assign fe_mode   = m_q.fe;
    assign wake_busy = |sect_busy;
    assign ref_run   = dom_q;
    assign dce_run   = dom_q;
    assign pll_run   = dom_q;
    assign bg_run    = 1'b1;
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] ch_en,
    input logic [1:0]     cnv_mode,
    input logic [1:0]     fe_mode,
    input logic           wake_busy,
    input logic           ref_run
);
    // R4
    no_chan_in_lp_chk: assert property (@(posedge clk) disable iff (rst)
        (cnv_mode != 2'd0) |-> (ch_en == '0));

    // R3
    fe_lp_needs_cnv_lp_chk: assert property (@(posedge clk) disable iff (rst)
        (fe_mode != 2'd0) |-> (cnv_mode != 2'd0));

    // R7
    no_busy_all_lp_chk: assert property (@(posedge clk) disable iff (rst)
        (cnv_mode != 2'd0 && fe_mode != 2'd0) |-> !wake_busy);

    // R6
    busy_start_from_lp_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_busy) |-> ($past(cnv_mode) != 2'd0 || $past(fe_mode) != 2'd0));

    // R8
    ref_follows_mode_chk: assert property (@(posedge clk) disable iff (rst)
        ref_run == (cnv_mode != 2'd2));

    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ch_en == '0 && cnv_mode == 2'd2 && fe_mode == 2'd2 && !wake_busy));
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(.NCH(NCH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ch_en     (ch_en),
    .cnv_mode  (cnv_mode),
    .fe_mode   (fe_mode),
    .wake_busy (wake_busy),
    .ref_run   (ref_run)
);

// File: tb/pwr_state_ctrl_test.sv
module pwr_state_ctrl_test;
    localparam int NCH = 8;
    localparam int CW  = 24;
    localparam int NAP_N = 3;
    localparam int SLP_N = 7;
    localparam int NV = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0, cw = 1'b0;
    logic [NCH-1:0] m0 = '0, m1 = '0;
    logic c0 = 1'b0, c1 = 1'b0, f0 = 1'b0, f1 = 1'b0;
    logic [CW-1:0] nap_n = CW'(NAP_N), slp_n = CW'(SLP_N);
    logic [NCH-1:0] ch_en;
    logic [1:0] cnv_mode, fe_mode;
    logic wake_busy, ref_run, dce_run, pll_run, bg_run;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwr_state_ctrl #(.NCH(NCH), .CW(CW)) uut (
        .clk(clk), .rst(rst),
        .prof_sel_async(sel), .cw_req_async(cw),
        .prof0_ch_mask(m0), .prof1_ch_mask(m1),
        .prof0_cnv_nap(c0), .prof1_cnv_nap(c1),
        .prof0_fe_nap(f0), .prof1_fe_nap(f1),
        .nap_wake_cyc(nap_n), .sleep_wake_cyc(slp_n),
        .ch_en(ch_en), .cnv_mode(cnv_mode), .fe_mode(fe_mode),
        .wake_busy(wake_busy), .ref_run(ref_run), .dce_run(dce_run),
        .pll_run(pll_run), .bg_run(bg_run)
    );

    // {sel, cw, mask0, mask1, {cnap0,cnap1,fnap0,fnap1}, exp_en, exp_cnv, exp_fe}
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'hA5, 8'h3C, 4'b0000, 8'hA5, 2'd0, 2'd0},
        {1'b1, 1'b0, 8'hA5, 8'h3C, 4'b0000, 8'h3C, 2'd0, 2'd0},
        {1'b0, 1'b1, 8'hA5, 8'h3C, 4'b0000, 8'h00, 2'd2, 2'd0},
        {1'b0, 1'b1, 8'hA5, 8'h3C, 4'b1000, 8'h00, 2'd1, 2'd0},
        {1'b0, 1'b0, 8'h00, 8'hFF, 4'b1010, 8'h00, 2'd1, 2'd1},
        {1'b0, 1'b0, 8'h00, 8'hFF, 4'b0000, 8'h00, 2'd2, 2'd2},
        {1'b1, 1'b0, 8'hFF, 8'h00, 4'b0101, 8'h00, 2'd1, 2'd1},
        {1'b1, 1'b0, 8'hFF, 8'h00, 4'b1010, 8'h00, 2'd2, 2'd2},
        {1'b1, 1'b1, 8'h00, 8'h81, 4'b0100, 8'h00, 2'd1, 2'd0},
        {1'b1, 1'b0, 8'h00, 8'h81, 4'b0100, 8'h81, 2'd0, 2'd0},
        {1'b0, 1'b0, 8'h01, 8'h00, 4'b0001, 8'h01, 2'd0, 2'd0},
        {1'b0, 1'b0, 8'h80, 8'h00, 4'b0001, 8'h80, 2'd0, 2'd0}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    function automatic int count_busy(input int win);
        return win;
    endfunction

    task automatic busy_len(output int n);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (wake_busy) n++;
        end
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all): actual hung expected finished");
            report();
        end
    end

    initial begin
        int n;
        // R9 reset state
        step(3);
        chk("R9 ch_en", ch_en, 0);
        chk("R9 cnv_mode", cnv_mode, 2);
        chk("R9 fe_mode", fe_mode, 2);
        chk("R9 wake_busy", wake_busy, 0);
        chk("R8 ref_run in reset", ref_run, 0);
        rst = 1'b0;
        step(25);

        // R1 R2 R3 R4 R8 vector table
        for (int v = 0; v < NV; v++) begin
            {sel, cw, m0, m1, c0, c1, f0, f1} = VEC[v][33:12];
            step(25);
            chk("R1/R4 ch_en", ch_en, VEC[v][11:4]);
            chk("R2 cnv_mode", cnv_mode, VEC[v][3:2]);
            chk("R3 fe_mode", fe_mode, VEC[v][1:0]);
            chk("R6 idle busy", wake_busy, 0);
            chk("R8 ref/dce/pll", {ref_run, dce_run, pll_run},
                (VEC[v][3:2] == 2'd2) ? 3'b000 : 3'b111);
            chk("R8 bg_run", bg_run, 1);
        end

        // R5 synchronizer latency
        {sel, cw, m0, m1, c0, c1, f0, f1} = {1'b0, 1'b0, 8'hA5, 8'h3C, 4'b0000};
        step(25);
        sel = 1'b1;
        step(2);
        chk("R5 sel not yet seen", ch_en, 8'hA5);
        step(1);
        chk("R5 sel seen at third edge", ch_en, 8'h3C);
        m1 = 8'h0F;
        step(1);
        chk("R5 mask at first edge", ch_en, 8'h0F);

        // R6 wake from nap
        m1 = 8'h00; c1 = 1'b1; f1 = 1'b1;
        step(25);
        chk("R6 parked in nap", cnv_mode, 1);
        m1 = 8'hF0;
        busy_len(n);
        chk("R6 nap wake length", n, NAP_N);

        // R6 wake from sleep
        m1 = 8'h00; c1 = 1'b0; f1 = 1'b0;
        step(25);
        chk("R6 parked in sleep", fe_mode, 2);
        m1 = 8'hF0;
        busy_len(n);
        chk("R6 sleep wake length", n, SLP_N);

        // R6 zero count
        m1 = 8'h00; c1 = 1'b1; f1 = 1'b1; nap_n = '0;
        step(25);
        m1 = 8'hF0;
        busy_len(n);
        chk("R6 zero nap count", n, 0);
        nap_n = CW'(NAP_N);

        // R7 abort during wake
        m1 = 8'h00; c1 = 1'b0; f1 = 1'b0;
        step(25);
        m1 = 8'hF0;
        step(2);
        chk("R7 wake running", wake_busy, 1);
        m1 = 8'h00;
        step(1);
        chk("R7 busy dropped", wake_busy, 0);
        chk("R7 new mode taken", cnv_mode, 2);

        // R9 reset from active
        m1 = 8'hFF;
        step(25);
        rst = 1'b1;
        step(1);
        chk("R9 ch_en cleared", ch_en, 0);
        chk("R9 modes sleep", {cnv_mode, fe_mode}, 4'b1010);
        chk("R9 busy cleared", wake_busy, 0);
        rst = 1'b0;
        step(2);

        done = 1'b1;
        report();
    end
endmodule